// File: doc/BRIEF.md
# Flash Write-Buffer Load Controller

This block runs the buffered-program command sequence of a parallel flash device. An upstream decoder recognises the two unlock writes and raises a one-cycle `prefix_done` pulse. The block then takes the following bus writes as the rest of the sequence. A load command names the sector. The next write gives the word count minus one. Each later write drops one data word into a 16-entry page register file, indexed by the low address bits. A confirm write to the same sector raises a one-cycle strobe toward the program engine, and the program engine then reads the captured words through a read port.

Any break of the sequence locks the block in an abort state. Examples are a count that is too large, a write outside the page, an extra word, or a confirm aimed at another sector. In the abort state the block ignores everything except its own three-write release sequence. That sequence is AAh to 555h, then 55h to 2AAh, then F0h to 555h. Only the low 11 address bits and the low data byte are compared.

States and transitions of the sequencer:
- `ST_IDLE` goes to `ST_ARMED` on `prefix_done`.
- `ST_ARMED` goes to `ST_COUNT` on a write whose data byte is 25h. Any other write sends it back to `ST_IDLE`.
- `ST_COUNT` goes to `ST_LOAD` on a valid count written to the same sector. Otherwise it goes to `ST_ABORT`.
- `ST_LOAD` stays in `ST_LOAD` while words are still owed. It goes to `ST_CONFIRM` when the last word arrives, and to `ST_ABORT` on a page or sector miss.
- `ST_CONFIRM` goes to `ST_IDLE` on a good confirm, or to `ST_ARMED` when `prefix_done` arrives in the same cycle. Any other write sends it to `ST_ABORT`.
- `ST_ABORT` goes to `ST_IDLE` when the release sequence completes.

Top module: `wbuf_load_ctrl`

## Requirements
- R1: After reset, `abort` and `prog_start` are 0 and `buf_valid` is all zero.
- R2: A write is taken as part of a sequence only after `prefix_done`. A write in idle is ignored. After the prefix, a write whose data bits [7:0] are not 25h returns the block to idle without an abort. A write of 25h captures the sector address bits [21:15] on `buf_sector` and clears `buf_valid`.
- R3: The write after 25h must hit the captured sector. Its data field is the word count minus one. A value above 15, or a different sector, sets `abort`.
- R4: Each load write stores `wr_data` at entry `wr_addr[3:0]`, sets that bit of `buf_valid`, and is readable on `rd_data` at `rd_idx`. The page is address bits [21:4] of the first word, and that first word must lie in the captured sector. A first word outside the sector sets `abort`.
- R5: A load write whose address bits [21:4] differ from the page sets `abort`.
- R6: Once the promised number of words is loaded, a write of 29h to the captured sector raises `prog_start` for exactly one cycle, starting the cycle after that write. At that point `buf_count` holds the count minus one.
- R7: An extra data write in place of the confirm, or a confirm to another sector, sets `abort` and gives no `prog_start`.
- R8: While `abort` is high, `prefix_done` and command writes have no effect. `abort` stays high.
- R9: `abort` clears in the cycle after three consecutive writes: data byte AAh to address 555h, 55h to 2AAh, and F0h to 555h. Only address bits [10:0] are compared. Any other write in between restarts the release sequence.
- R10: When `prefix_done` arrives in the same cycle as a good confirm write, `prog_start` still fires and the block is armed for the next 25h command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prefix_done | input | 1 | Pulse from the unlock decoder: the next write is a command |
| wr_valid | input | 1 | A bus write cycle is present this clock |
| wr_addr | input | 22 | Write word address |
| wr_data | input | 16 | Write data |
| rd_idx | input | 4 | Buffer entry to read |
| rd_data | output | 16 | Buffer word at `rd_idx` |
| buf_valid | output | 16 | One bit per buffer entry written in this sequence |
| buf_sector | output | 7 | Captured sector address |
| buf_page | output | 18 | Captured page address |
| buf_count | output | 4 | Word count minus one |
| prog_start | output | 1 | One-cycle strobe to the program engine |
| abort | output | 1 | Sequence abort flag |

## Verification
Two functions can land in the same clock: finishing a sequence with its confirm write, and accepting the unlock prefix for the next command. The bench drives `prefix_done` together with the 29h write. It expects `prog_start` in the following cycle, and then sends a 25h command with no new prefix pulse. The test passes only if that second sequence loads and strobes again. The final data word and the switch to awaiting confirm also share a cycle. This is checked by full 16-entry loads, where every entry must read back and the confirm must still be accepted.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARMED   = 3'd1,
        ST_COUNT   = 3'd2,
        ST_LOAD    = 3'd3,
        ST_CONFIRM = 3'd4,
        ST_ABORT   = 3'd5
    } wbuf_state_e;

    localparam logic [7:0] CMD_LOAD    = 8'h25;
    localparam logic [7:0] CMD_CONFIRM = 8'h29;
    localparam logic [7:0] KEY_FIRST   = 8'hAA;
    localparam logic [7:0] KEY_SECOND  = 8'h55;
    localparam logic [7:0] KEY_EXIT    = 8'hF0;
    localparam int         KEY_ADDR_W  = 11;
    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_A = 11'h555;
    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_B = 11'h2AA;

endpackage

// File: rtl/wbuf_page_regs.sv
module wbuf_page_regs #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    we,
    input  logic [IDX_W-1:0]        widx,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [IDX_W-1:0]        ridx,
    output logic [DATA_W-1:0]       rdata,
    output logic [(2**IDX_W)-1:0]   valid
);
    localparam int WORDS = 2 ** IDX_W;

    logic [DATA_W-1:0] mem [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_entry
        logic hit;
        assign hit = we && (widx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (hit) begin
                mem[i] <= wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[i] <= 1'b0;
            end else if (clr) begin
                valid[i] <= 1'b0;
            end else if (hit) begin
                valid[i] <= 1'b1;
            end
        end
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/wbuf_abort_exit.sv
module wbuf_abort_exit
    import wbuf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  active,
    input  logic                  wr_valid,
    input  logic [KEY_ADDR_W-1:0] key_addr,
    input  logic [7:0]            key_data,
    output logic                  done
);
    typedef enum logic [1:0] {
        KS_WAIT_AA = 2'd0,
        KS_WAIT_55 = 2'd1,
        KS_WAIT_F0 = 2'd2
    } key_step_e;

    key_step_e step_q, step_d;
    logic      is_first, is_second, is_exit;

    assign is_first  = (key_addr == KEY_ADDR_A) && (key_data == KEY_FIRST);
    assign is_second = (key_addr == KEY_ADDR_B) && (key_data == KEY_SECOND);
    assign is_exit   = (key_addr == KEY_ADDR_A) && (key_data == KEY_EXIT);

    always_comb begin
        step_d = step_q;
        if (!active) begin
            step_d = KS_WAIT_AA;
        end else if (wr_valid) begin
            unique case (step_q)
                KS_WAIT_AA: step_d = is_first ? KS_WAIT_55 : KS_WAIT_AA;
                KS_WAIT_55: step_d = is_second ? KS_WAIT_F0 :
                                     (is_first ? KS_WAIT_55 : KS_WAIT_AA);
                KS_WAIT_F0: step_d = is_exit ? KS_WAIT_AA :
                                     (is_first ? KS_WAIT_55 : KS_WAIT_AA);
                default:    step_d = KS_WAIT_AA;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= KS_WAIT_AA;
        end else begin
            step_q <= step_d;
        end
    end

    assign done = active && wr_valid && (step_q == KS_WAIT_F0) && is_exit;

endmodule

// File: rtl/wbuf_seq_fsm.sv
module wbuf_seq_fsm
    import wbuf_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 15,
    parameter int IDX_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        prefix_done,
    input  logic                        wr_valid,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        exit_done,
    output logic                        in_abort,
    output logic                        buf_clr,
    output logic                        buf_we,
    output logic [IDX_W-1:0]            buf_widx,
    output logic [ADDR_W-SECT_LSB-1:0]  sector_q,
    output logic [ADDR_W-IDX_W-1:0]     page_q,
    output logic [IDX_W-1:0]            count_q,
    output logic                        prog_q
);
    localparam int SECT_W = ADDR_W - SECT_LSB;
    localparam int PAGE_W = ADDR_W - IDX_W;

    wbuf_state_e state_q, state_d;

    logic [SECT_W-1:0] wr_sect;
    logic [PAGE_W-1:0] wr_page;
    logic [7:0]        cmd;
    logic              sect_hit;
    logic              page_hit;
    logic              count_ok;
    logic [IDX_W:0]    loaded_q;
    logic              first_word;
    logic              last_word;
    logic              word_ok;
    logic              open_cmd;
    logic              count_take;
    logic              good_confirm;

    assign wr_sect    = wr_addr[ADDR_W-1:SECT_LSB];
    assign wr_page    = wr_addr[ADDR_W-1:IDX_W];
    assign cmd        = wr_data[7:0];
    assign sect_hit   = (wr_sect == sector_q);
    assign page_hit   = (wr_page == page_q);
    assign count_ok   = (wr_data[DATA_W-1:IDX_W] == '0);
    assign first_word = (loaded_q == '0);
    assign last_word  = (loaded_q == {1'b0, count_q});
    assign word_ok    = first_word ? sect_hit : page_hit;

    assign open_cmd     = (state_q == ST_ARMED) && wr_valid && (cmd == CMD_LOAD);
    assign count_take   = (state_q == ST_COUNT) && wr_valid && sect_hit && count_ok;
    assign good_confirm = (state_q == ST_CONFIRM) && wr_valid && sect_hit
                          && (cmd == CMD_CONFIRM);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (prefix_done) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (wr_valid) state_d = (cmd == CMD_LOAD) ? ST_COUNT : ST_IDLE;
            end
            ST_COUNT: begin
                if (wr_valid) state_d = (sect_hit && count_ok) ? ST_LOAD : ST_ABORT;
            end
            ST_LOAD: begin
                if (wr_valid) begin
                    if (!word_ok)       state_d = ST_ABORT;
                    else if (last_word) state_d = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (wr_valid) begin
                    if (good_confirm) state_d = prefix_done ? ST_ARMED : ST_IDLE;
                    else              state_d = ST_ABORT;
                end
            end
            ST_ABORT: begin
                if (exit_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs and captured fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sector_q <= '0;
            page_q   <= '0;
            count_q  <= '0;
            loaded_q <= '0;
            prog_q   <= 1'b0;
        end else begin
            prog_q <= good_confirm;
            if (open_cmd) begin
                sector_q <= wr_sect;
            end
            if (count_take) begin
                count_q  <= wr_data[IDX_W-1:0];
                loaded_q <= '0;
            end
            if (buf_we) begin
                loaded_q <= loaded_q + 1'b1;
                if (first_word) page_q <= wr_page;
            end
        end
    end

    assign in_abort = (state_q == ST_ABORT);
    assign buf_clr  = open_cmd;
    assign buf_we   = (state_q == ST_LOAD) && wr_valid && word_ok;
    assign buf_widx = wr_addr[IDX_W-1:0];

endmodule

// File: rtl/wbuf_load_ctrl.sv
module wbuf_load_ctrl
    import wbuf_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 15,
    parameter int IDX_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        prefix_done,
    input  logic                        wr_valid,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [DATA_W-1:0]           rd_data,
    output logic [(2**IDX_W)-1:0]       buf_valid,
    output logic [ADDR_W-SECT_LSB-1:0]  buf_sector,
    output logic [ADDR_W-IDX_W-1:0]     buf_page,
    output logic [IDX_W-1:0]            buf_count,
    output logic                        prog_start,
    output logic                        abort
);
    logic             in_abort;
    logic             exit_done;
    logic             buf_clr;
    logic             buf_we;
    logic [IDX_W-1:0] buf_widx;

    wbuf_seq_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SECT_LSB (SECT_LSB),
        .IDX_W    (IDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .prefix_done (prefix_done),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .exit_done   (exit_done),
        .in_abort    (in_abort),
        .buf_clr     (buf_clr),
        .buf_we      (buf_we),
        .buf_widx    (buf_widx),
        .sector_q    (buf_sector),
        .page_q      (buf_page),
        .count_q     (buf_count),
        .prog_q      (prog_start)
    );

    wbuf_abort_exit u_exit (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (in_abort),
        .wr_valid (wr_valid),
        .key_addr (wr_addr[KEY_ADDR_W-1:0]),
        .key_data (wr_data[7:0]),
        .done     (exit_done)
    );

    wbuf_page_regs #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr),
        .we    (buf_we),
        .widx  (buf_widx),
        .wdata (wr_data),
        .ridx  (rd_idx),
        .rdata (rd_data),
        .valid (buf_valid)
    );

    assign abort = in_abort;

endmodule

// File: rtl/wbuf_load_ctrl_chk.sv
module wbuf_load_ctrl_chk #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_valid,
    input logic [10:0]           key_addr,
    input logic [7:0]            key_data,
    input logic [(2**IDX_W)-1:0] buf_valid,
    input logic [IDX_W-1:0]      buf_count,
    input logic                  prog_start,
    input logic                  abort
);
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!abort && !prog_start && buf_valid == '0));

    assert_valid_moves_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(buf_valid) |-> $past(wr_valid));

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start);

    assert_strobe_after_confirm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> $past(wr_valid && key_data == 8'h29));

    assert_strobe_within_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> ($countones(buf_valid) <= int'(buf_count) + 1));

    assert_no_strobe_in_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_start && abort));

    assert_abort_exit_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(abort) |-> $past(wr_valid && key_addr == 11'h555 && key_data == 8'hF0));

endmodule

bind wbuf_load_ctrl wbuf_load_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .key_addr   (wr_addr[10:0]),
    .key_data   (wr_data[7:0]),
    .buf_valid  (buf_valid),
    .buf_count  (buf_count),
    .prog_start (prog_start),
    .abort      (abort)
);

// File: tb/wbuf_load_ctrl_bench.sv
module wbuf_load_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [21:0] SA   = 22'h0A8000;
    localparam logic [21:0] OTHR = 22'h0B0000;
    localparam logic [21:0] A555 = 22'h000555;
    localparam logic [21:0] A2AA = 22'h0002AA;
    localparam int NVEC = 13;

    // {prefix, wr_valid, addr, data, exp_abort, exp_prog}
    localparam logic [41:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 22'h0,      16'h0000, 1'b0, 1'b0},
        {1'b0, 1'b1, SA,         16'h0025, 1'b0, 1'b0},
        {1'b0, 1'b1, SA,         16'h0010, 1'b1, 1'b0},
        {1'b0, 1'b1, A555,       16'h00AA, 1'b1, 1'b0},
        {1'b0, 1'b1, A2AA,       16'h0055, 1'b1, 1'b0},
        {1'b0, 1'b1, A555,       16'h00F0, 1'b0, 1'b0},
        {1'b1, 1'b0, 22'h0,      16'h0000, 1'b0, 1'b0},
        {1'b0, 1'b1, SA,         16'h0025, 1'b0, 1'b0},
        {1'b0, 1'b1, SA,         16'h0002, 1'b0, 1'b0},
        {1'b0, 1'b1, 22'h0A8123, 16'h1111, 1'b0, 1'b0},
        {1'b0, 1'b1, 22'h0A8120, 16'h2222, 1'b0, 1'b0},
        {1'b0, 1'b1, 22'h0A812F, 16'h3333, 1'b0, 1'b0},
        {1'b0, 1'b1, SA,         16'h0029, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prefix_done = 1'b0;
    logic        wr_valid = 1'b0;
    logic [21:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic [15:0] buf_valid;
    logic [6:0]  buf_sector;
    logic [17:0] buf_page;
    logic [3:0]  buf_count;
    logic        prog_start;
    logic        abort;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbuf_load_ctrl u_wbuf_load_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .prefix_done (prefix_done),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data),
        .buf_valid   (buf_valid),
        .buf_sector  (buf_sector),
        .buf_page    (buf_page),
        .buf_count   (buf_count),
        .prog_start  (prog_start),
        .abort       (abort)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic pre, input logic wv, input logic [21:0] a, input logic [15:0] d);
        @(negedge clk);
        prefix_done = pre;
        wr_valid    = wv;
        wr_addr     = a;
        wr_data     = d;
        @(negedge clk);
        prefix_done = 1'b0;
        wr_valid    = 1'b0;
    endtask

    task automatic wr(input logic [21:0] a, input logic [15:0] d);
        step(1'b0, 1'b1, a, d);
    endtask

    task automatic open_seq(input logic [15:0] cnt);
        step(1'b1, 1'b0, '0, '0);
        wr(SA, 16'h0025);
        wr(SA, cnt);
    endtask

    task automatic leave_abort();
        wr(A555, 16'h00AA);
        wr(A2AA, 16'h0055);
        wr(A555, 16'h00F0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 abort", abort, 0);
        check("R1 prog_start", prog_start, 0);
        check("R1 buf_valid", buf_valid, 0);
        rst_n = 1'b1;

        // vector table: R3 count overflow, R9 release, R4/R6 small load
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][41], VEC[i][40], VEC[i][39:18], VEC[i][17:2]);
            check($sformatf("R3/R6/R9 vec%0d abort", i), abort, VEC[i][1]);
            check($sformatf("R6 vec%0d prog_start", i), prog_start, VEC[i][0]);
        end
        check("R4 valid after table", buf_valid, 16'h8009);
        check("R6 count after table", buf_count, 2);
        check("R2 sector captured", buf_sector, 7'h15);
        check("R4 page captured", buf_page, 18'h0A812);
        rd_idx = 4'h3; #1 check("R4 entry 3", rd_data, 16'h1111);
        rd_idx = 4'h0; #1 check("R4 entry 0", rd_data, 16'h2222);
        rd_idx = 4'hF; #1 check("R4 entry 15", rd_data, 16'h3333);
        @(negedge clk);
        check("R6 strobe one cycle", prog_start, 0);

        // R4/R6 full 16-word load
        open_seq(16'h000F);
        for (int i = 0; i < 16; i++) wr(22'h0A8130 + 22'(i), 16'hA000 + 16'(i));
        check("R6 no strobe before confirm", prog_start, 0);
        wr(SA, 16'h0029);
        check("R6 full load strobe", prog_start, 1);
        check("R6 full count", buf_count, 4'hF);
        check("R4 full valid", buf_valid, 16'hFFFF);
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            #1 check($sformatf("R4 full entry %0d", i), rd_data, 16'hA000 + 16'(i));
        end

        // R2 idle write ignored, non-load command returns idle
        wr(SA, 16'h0025);
        wr(SA, 16'h0000);
        check("R2 idle write ignored valid", buf_valid, 16'hFFFF);
        check("R2 idle write no abort", abort, 0);
        step(1'b1, 1'b0, '0, '0);
        wr(SA, 16'h0080);
        wr(SA, 16'h0003);
        check("R2 other command no abort", abort, 0);
        check("R2 other command valid kept", buf_valid, 16'hFFFF);

        // R5 page mismatch
        open_seq(16'h0001);
        wr(22'h0A8140, 16'h0001);
        check("R5 first word ok", abort, 0);
        wr(22'h0A8150, 16'h0002);
        check("R5 page miss aborts", abort, 1);
        leave_abort();
        check("R9 released", abort, 0);

        // R7 extra word
        open_seq(16'h0000);
        wr(22'h0A8140, 16'h0001);
        wr(22'h0A8141, 16'h0002);
        check("R7 extra word aborts", abort, 1);
        check("R7 extra word no strobe", prog_start, 0);
        leave_abort();

        // R7 confirm to another sector
        open_seq(16'h0000);
        wr(22'h0A8140, 16'h0001);
        wr(OTHR, 16'h0029);
        check("R7 wrong sector confirm aborts", abort, 1);
        check("R7 wrong sector no strobe", prog_start, 0);
        leave_abort();

        // R3 count to another sector
        step(1'b1, 1'b0, '0, '0);
        wr(SA, 16'h0025);
        wr(OTHR, 16'h0001);
        check("R3 count sector miss aborts", abort, 1);
        leave_abort();

        // R4 first word outside sector
        open_seq(16'h0000);
        wr(OTHR, 16'h0001);
        check("R4 first word sector miss aborts", abort, 1);
        leave_abort();

        // R8 lock and R9 broken release
        open_seq(16'h0020);
        check("R3 count 20h aborts", abort, 1);
        step(1'b1, 1'b0, '0, '0);
        wr(SA, 16'h0025);
        wr(SA, 16'h0000);
        wr(22'h0A8140, 16'h0001);
        wr(SA, 16'h0029);
        check("R8 locked abort", abort, 1);
        check("R8 locked no strobe", prog_start, 0);
        wr(A555, 16'h00AA);
        wr(A2AA, 16'h0055);
        wr(A555, 16'h0090);
        wr(A555, 16'h00F0);
        check("R9 broken release stays", abort, 1);
        leave_abort();
        check("R9 release after restart", abort, 0);

        // R10 prefix with confirm in the same cycle
        open_seq(16'h0000);
        wr(22'h0A8140, 16'h0077);
        step(1'b1, 1'b1, SA, 16'h0029);
        check("R10 strobe with prefix", prog_start, 1);
        wr(SA, 16'h0025);
        wr(SA, 16'h0000);
        wr(22'h0A8145, 16'h0088);
        wr(SA, 16'h0029);
        check("R10 armed sequence strobes", prog_start, 1);
        check("R10 armed sequence valid", buf_valid, 16'h0020);
        check("R10 no abort", abort, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule